// File: doc/BRIEF.md
# Serial DAC Frame Transmitter

This block sits on the controller side of a three-wire link to a 12-bit serial digital-to-analog converter. A client hands it a 12-bit code over a valid/ready handshake. The block builds a 16-bit frame: four zero padding bits go out first, then the code from its most significant bit down to its least significant bit. It drives a serial clock, a serial data line and an active-low frame sync, and the converter samples each bit on a falling clock edge.

The serial clock comes from a divider of the system clock, with a parameter setting the length of each half period. Two options are taken from the inputs when a code is accepted. The first splits the frame into two eight-bit bursts under one sync window, to suit hosts that shift bytes. The second asks for a separate load strobe after the frame ends, so the converter output changes under the host's control rather than on the last clock edge.

Top module: `dac_serial_tx`

## Requirements
- R1: Out of reset, and whenever the block is idle, `sync_n` and `sclk` are 1, and `sdata`, `load_pulse` and nothing else are 0, while `in_ready` is 1.
- R2: A code is accepted at the clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the next cycle until the frame and any load strobe have finished.
- R3: Each frame carries exactly 16 bits on the falling edges of `sclk`. The first four bits are 0, followed by `in_data[11]` down to `in_data[0]`.
- R4: `sclk` is 1 outside a frame. Each low and high phase lasts HALF_DIV system clocks, and `sdata` changes only while `sclk` is high, never during a low phase.
- R5: `sync_n` falls in the cycle after acceptance and stays low for HALF_DIV clocks before the first falling edge. It rises HALF_DIV clocks after the last rising edge of `sclk`.
- R6: With `byte_mode` 1 at acceptance, the high phase after the eighth falling edge lasts 2*HALF_DIV clocks, giving two bursts of eight falling edges while `sync_n` stays low.
- R7: With `defer_load` 1 at acceptance, `load_pulse` is 1 for LOAD_CLKS clocks, starting 2*HALF_DIV clocks after `sync_n` rises. `in_ready` returns to 1 in the cycle after the strobe ends.
- R8: With `defer_load` 0 at acceptance, `load_pulse` stays 0, and `in_ready` returns to 1 in the cycle after `sync_n` rises.
- R9: The code and both mode inputs are captured at acceptance. Changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A code is offered |
| in_ready | output | 1 | Block can accept a code |
| in_data | input | 12 | Code to send |
| byte_mode | input | 1 | Send the frame as two eight-bit bursts |
| defer_load | input | 1 | Issue a load strobe after the frame |
| sclk | output | 1 | Serial clock, idles high |
| sdata | output | 1 | Serial data, sampled on falling `sclk` |
| sync_n | output | 1 | Active-low frame sync |
| load_pulse | output | 1 | Active-high converter load strobe |

## Verification
The assertions assume that `in_valid` and the inputs it qualifies change only between clock edges, and that no code is offered while reset is asserted. The bench drives every input one time unit after a rising edge and releases reset before the first offer. It also deliberately moves `in_data` and the mode inputs while a frame is in flight, which checks that only the values captured at acceptance matter.

// File: rtl/dacs_pkg.sv
package dacs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LEAD  = 3'd1,
    ST_SHIFT = 3'd2,
    ST_GAP   = 3'd3,
    ST_TAIL  = 3'd4,
    ST_WAIT  = 3'd5,
    ST_LOAD  = 3'd6
  } dacs_state_e;

  function automatic int unsigned dacs_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dacs_divider.sv
module dacs_divider #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic [CNT_W-1:0] limit,
  output logic             tick
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign tick   = !hold && (cnt_q == limit);
  assign cnt_en = 1'b1;

  always_comb begin
    if (hold || tick) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/dacs_shifter.sv
module dacs_shifter #(
  parameter int unsigned DATA_W  = 12,
  parameter int unsigned FRAME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] data,
  output logic              bit_out
);

  localparam int unsigned PAD_W = FRAME_W - DATA_W;

  logic [FRAME_W-1:0] sr_q, sr_d;
  logic               sr_en;

  assign sr_en   = load || shift;
  assign bit_out = sr_q[FRAME_W-1];

  generate
    if (PAD_W > 0) begin : g_pad
      always_comb begin
        if (load) begin
          sr_d = {{PAD_W{1'b0}}, data};
        end else begin
          sr_d = {sr_q[FRAME_W-2:0], 1'b0};
        end
      end
    end else begin : g_nopad
      always_comb begin
        if (load) begin
          sr_d = data[FRAME_W-1:0];
        end else begin
          sr_d = {sr_q[FRAME_W-2:0], 1'b0};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (sr_en) begin
      sr_q <= sr_d;
    end
  end

endmodule

// File: rtl/dac_serial_tx.sv
module dac_serial_tx
  import dacs_pkg::*;
#(
  parameter int unsigned DATA_W    = 12,
  parameter int unsigned FRAME_W   = 16,
  parameter int unsigned BURST_W   = 8,
  parameter int unsigned HALF_DIV  = 2,
  parameter int unsigned LOAD_CLKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              byte_mode,
  input  logic              defer_load,
  output logic              sclk,
  output logic              sdata,
  output logic              sync_n,
  output logic              load_pulse
);

  localparam int unsigned MAXV  = dacs_max(2 * HALF_DIV, LOAD_CLKS);
  localparam int unsigned CNT_W = $clog2(MAXV + 1);
  localparam int unsigned BIT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] HALF_LIM = CNT_W'(HALF_DIV - 1);
  localparam logic [CNT_W-1:0] WAIT_LIM = CNT_W'(2 * HALF_DIV - 1);
  localparam logic [CNT_W-1:0] LOAD_LIM = CNT_W'(LOAD_CLKS - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);
  localparam logic [BIT_W-1:0] BURST_END = BIT_W'(BURST_W - 1);

  dacs_state_e      state_q, state_d;
  logic [BIT_W-1:0] bits_q, bits_d;
  logic             byte_q, byte_d;
  logic             defer_q, defer_d;
  logic             sclk_q, sclk_d;
  logic             sync_q, sync_d;
  logic             load_q, load_d;
  logic             sh_load, sh_shift;
  logic             tick;
  logic             hold;
  logic [CNT_W-1:0] limit;
  logic             ctl_en;

  assign hold   = (state_q == ST_IDLE);
  assign ctl_en = 1'b1;

  always_comb begin
    case (state_q)
      ST_WAIT: limit = WAIT_LIM;
      ST_LOAD: limit = LOAD_LIM;
      default: limit = HALF_LIM;
    endcase
  end

  dacs_divider #(
    .CNT_W (CNT_W)
  ) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (hold),
    .limit (limit),
    .tick  (tick)
  );

  dacs_shifter #(
    .DATA_W  (DATA_W),
    .FRAME_W (FRAME_W)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (sh_load),
    .shift   (sh_shift),
    .data    (in_data),
    .bit_out (sdata)
  );

  always_comb begin
    state_d  = state_q;
    bits_d   = bits_q;
    byte_d   = byte_q;
    defer_d  = defer_q;
    sclk_d   = sclk_q;
    sync_d   = sync_q;
    load_d   = load_q;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (in_valid) begin
          state_d = ST_LEAD;
          sync_d  = 1'b0;
          sh_load = 1'b1;
          bits_d  = '0;
          byte_d  = byte_mode;
          defer_d = defer_load;
        end
      end
      ST_LEAD: begin
        if (tick) begin
          sclk_d  = 1'b0;
          state_d = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (tick) begin
          if (!sclk_q) begin
            sclk_d   = 1'b1;
            sh_shift = 1'b1;
            bits_d   = bits_q + 1'b1;
            if (bits_q == LAST_BIT) begin
              state_d = ST_TAIL;
            end else if (byte_q && (bits_q == BURST_END)) begin
              state_d = ST_GAP;
            end
          end else begin
            sclk_d = 1'b0;
          end
        end
      end
      ST_GAP: begin
        if (tick) begin
          state_d = ST_SHIFT;
        end
      end
      ST_TAIL: begin
        if (tick) begin
          sync_d  = 1'b1;
          state_d = defer_q ? ST_WAIT : ST_IDLE;
        end
      end
      ST_WAIT: begin
        if (tick) begin
          load_d  = 1'b1;
          state_d = ST_LOAD;
        end
      end
      ST_LOAD: begin
        if (tick) begin
          load_d  = 1'b0;
          state_d = ST_IDLE;
        end
      end
      default: begin
        state_d = ST_IDLE;
        sclk_d  = 1'b1;
        sync_d  = 1'b1;
        load_d  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bits_q  <= '0;
      byte_q  <= 1'b0;
      defer_q <= 1'b0;
      sclk_q  <= 1'b1;
      sync_q  <= 1'b1;
      load_q  <= 1'b0;
    end else if (ctl_en) begin
      state_q <= state_d;
      bits_q  <= bits_d;
      byte_q  <= byte_d;
      defer_q <= defer_d;
      sclk_q  <= sclk_d;
      sync_q  <= sync_d;
      load_q  <= load_d;
    end
  end

  assign in_ready   = (state_q == ST_IDLE);
  assign sclk       = sclk_q;
  assign sync_n     = sync_q;
  assign load_pulse = load_q;

endmodule

// File: rtl/dacs_checker.sv
module dacs_checker (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic sclk,
  input logic sdata,
  input logic sync_n,
  input logic load_pulse
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (sync_n && sclk && !load_pulse)); // R1

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R2

  AST_NO_READY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n |-> !in_ready); // R2

  AST_SCLK_HIGH_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_n |-> sclk); // R4

  AST_DATA_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk && !$past(sclk)) |-> $stable(sdata)); // R4

  AST_SYNC_FALL_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_n) |-> $past(in_valid && in_ready)); // R5

  AST_LOAD_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |-> (sync_n && sclk && !in_ready)); // R7

endmodule

bind dac_serial_tx dacs_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .sclk       (sclk),
  .sdata      (sdata),
  .sync_n     (sync_n),
  .load_pulse (load_pulse)
);

// File: tb/tb_dac_serial_tx.sv
module tb_dac_serial_tx;

  localparam int H = 2;
  localparam int L = 3;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [11:0] in_data;
  logic        byte_mode;
  logic        defer_load;
  logic        sclk;
  logic        sdata;
  logic        sync_n;
  logic        load_pulse;

  int total = 0;
  int bad   = 0;

  dac_serial_tx #(
    .DATA_W    (12),
    .FRAME_W   (16),
    .BURST_W   (8),
    .HALF_DIV  (H),
    .LOAD_CLKS (L)
  ) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .byte_mode  (byte_mode),
    .defer_load (defer_load),
    .sclk       (sclk),
    .sdata      (sdata),
    .sync_n     (sync_n),
    .load_pulse (load_pulse)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // expected {ready, sync_n, sclk, sdata, load} per cycle after acceptance
  logic [4:0] expq[$];
  logic [12:0] frameq[$];   // {byte_mode, code}
  bit   cur_defer = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push_frame(input logic [11:0] v, input bit bm, input bit dl);
    logic [15:0] f;
    f = {4'b0000, v};
    for (int k = 0; k < H; k++) expq.push_back({1'b0, 1'b0, 1'b1, f[15], 1'b0});
    for (int i = 0; i < 16; i++) begin
      logic b, nb;
      int hi;
      b  = f[15-i];
      nb = (i < 15) ? f[14-i] : 1'b0;
      for (int k = 0; k < H; k++) expq.push_back({1'b0, 1'b0, 1'b0, b, 1'b0});
      hi = (bm && i == 7) ? 2 * H : H;
      for (int k = 0; k < hi; k++) expq.push_back({1'b0, 1'b0, 1'b1, nb, 1'b0});
    end
    if (dl) begin
      for (int k = 0; k < 2 * H; k++) expq.push_back(5'b01100);
      for (int k = 0; k < L; k++)     expq.push_back(5'b01101);
    end
    frameq.push_back({bm, v});
  endtask

  // cycle model comparison and wire-level decode
  logic        prev_sclk = 1'b1;
  logic        prev_sync = 1'b1;
  int          nbits = 0;
  logic [15:0] word = '0;
  int          run = 0;
  int          maxrun = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      logic [4:0] e;
      logic [4:0] a;
      e = (expq.size() > 0) ? expq.pop_front() : 5'b11100;
      a = {in_ready, sync_n, sclk, sdata, load_pulse};
      check(a[4] == e[4], "R2 ready", a[4], e[4]);
      check(a[3] == e[3], "R5 sync_n", a[3], e[3]);
      check(a[2] == e[2], "R4 sclk", a[2], e[2]);
      check(a[1] == e[1], "R3 sdata", a[1], e[1]);
      if (cur_defer) check(a[0] == e[0], "R7 load_pulse", a[0], e[0]);
      else           check(a[0] == e[0], "R8 load_pulse", a[0], e[0]);

      if (!sync_n) begin
        if (prev_sclk && !sclk) begin
          word = {word[14:0], sdata};
          nbits++;
          if (nbits > 1 && run > maxrun) maxrun = run;
          run = 0;
        end
        if (sclk && nbits > 0) run++;
      end
      if (!prev_sync && sync_n) begin
        logic [12:0] fr;
        fr = (frameq.size() > 0) ? frameq.pop_front() : 13'h0;
        check(nbits == 16, "R3 bit count", nbits, 16);
        check(word == {4'b0000, fr[11:0]}, "R3 word", word, {4'b0000, fr[11:0]});
        check(maxrun == (fr[12] ? 2 * H : H), fr[12] ? "R6 burst gap" : "R4 high phase",
              maxrun, fr[12] ? 2 * H : H);
        nbits = 0; word = '0; run = 0; maxrun = 0;
      end
      prev_sclk = sclk;
      prev_sync = sync_n;

      if (in_valid && in_ready) begin
        cur_defer = defer_load;
        push_frame(in_data, byte_mode, defer_load);
      end
    end
  end

  task automatic send(input logic [11:0] v, input bit bm, input bit dl, input bit scramble);
    @(posedge clk); #1;
    in_valid = 1'b1; in_data = v; byte_mode = bm; defer_load = dl;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
    if (scramble) begin
      // R9: inputs moved mid-frame must not alter the frame in flight
      in_data = ~v; byte_mode = ~bm; defer_load = ~dl;
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; byte_mode = 1'b0; defer_load = 1'b0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({in_ready, sync_n, sclk, sdata, load_pulse} == 5'b11100, "R1 reset",
          {in_ready, sync_n, sclk, sdata, load_pulse}, 5'b11100);
    send(12'hABC, 1'b0, 1'b0, 1'b0);   // R3 R8 plain frame
    send(12'h001, 1'b1, 1'b0, 1'b0);   // R6 byte bursts
    send(12'hFFF, 1'b0, 1'b1, 1'b0);   // R7 deferred load
    send(12'h800, 1'b1, 1'b1, 1'b1);   // R9 scrambled after accept
    send(12'h5A3, 1'b0, 1'b0, 1'b1);   // R9 again, back to back
    send(12'h000, 1'b1, 1'b0, 1'b0);   // R2 back-to-back offer
    for (int n = 0; n < 4; n++) send(12'(n * 12'h3C5 + 7), n[0], n[1], 1'b0);
    while (expq.size() > 0 || !in_ready) @(negedge clk);
    repeat (4) @(negedge clk);
    check(frameq.size() == 0, "R3 frames seen", frameq.size(), 0);
    finish_run();
  end

endmodule